// File: doc/BRIEF.md
# Configurable Boolean Network Cell Grid

A small two-dimensional grid of state cells in which both the update rule of every cell and the wiring that feeds it can be set independently. Each cell keeps one state bit, a 16-entry truth table, four source selectors that pick the four truth-table address bits, and four direction selectors that decide what the cell sends to each of its four neighbours. A neighbour link can carry the sending cell's own state. It can also pass one of the sending cell's inputs straight through, so a signal can reach cells that are not adjacent. Links need not be symmetric or uniform.

The grid is configured one cell at a time through an index/data write port. Initial states are loaded in parallel through a seed port. Each step pulse advances every cell at once from the states held before the pulse. All states are visible as one vector. The block is meant to sit under a controller that searches rules and wiring. The grid only evaluates a chosen configuration.

Top module: `rbn_array`

## Requirements
- R1: After reset every state bit is 0 and every cell configuration is all-zero, so a step taken straight after reset leaves all states at 0.
- R2: A configuration write with `cfg_we_i` high changes only the cell whose index `row*COLS+col` equals `cfg_addr_i`; the new configuration applies from the next cycle.
- R3: The configuration word holds the truth table in bits [15:0]. On a step, the next state of a cell is truth-table bit `{a3,a2,a1,a0}`, where `ak` is the value picked by source selector k.
- R4: Source selector k sits in configuration bits [18+3k:16+3k]. Code 0 picks the cell's own state, 1 the north input, 2 the south input, 3 the east input and 4 the west input. Codes 5 to 7 pick a constant 0.
- R5: The direction selectors sit in configuration bits [30:28] (north), [33:31] (south), [36:34] (east) and [39:37] (west). Code 0 sends the cell's own state. Codes 1 to 4 pass the north, south, east or west input through unchanged and without a clock delay. Codes 5 to 7 send 0.
- R6: Grid edges wrap. Row 0's north neighbour is the last row, and column 0's west neighbour is the last column.
- R7: All cells update on the same step from the states held before it, so two cells that copy each other exchange values.
- R8: `seed_we_i` loads `seed_i` into the states, with bit i going to cell i. It takes priority over `step_i` in the same cycle.
- R9: With neither `seed_we_i` nor `step_i` high, every state holds its value.
- R10: Links are directional. A cell reading a neighbour does not make that neighbour read it.
- R11: When several source selectors pick the same signal, the rule acts on fewer distinct inputs. An exclusive-or of one signal with itself is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Index of the cell to configure |
| cfg_data_i | input | 40 | Cell configuration: truth table, source selectors, direction selectors |
| seed_we_i | input | 1 | Load all states from `seed_i` |
| seed_i | input | 16 | Seed value, bit i for cell i |
| step_i | input | 1 | Advance all states by one step |
| state_o | output | 16 | Current states, bit i for cell i |

## Verification
The truth-table lookup is driven with all sixteen address patterns. Each pattern is run once against a one-hot table and once against its complement, which shows that each address bit comes from its own selector in the right position. Seeds are used that set only the selected source, and then everything except it. These separate the five source codes from each other and from the constant code. Cells on the grid edge test the wraparound, and a pair of mutual copies tests that the update is simultaneous. A two-hop route through a pass-through output confirms that the link is combinational and that the zero code blocks it. Seeding while stepping, cells that read a neighbour in one direction only, and duplicated selectors feeding an exclusive-or cover the priority, asymmetry and reduced-input cases.

// File: rtl/rbn_pkg.sv
package rbn_pkg;
  localparam int SEL_W   = 3;
  localparam int LUT_IN  = 4;
  localparam int LUT_W   = 1 << LUT_IN;
  localparam int NUM_DIR = 4;  // 0 north, 1 south, 2 east, 3 west

  localparam logic [SEL_W-1:0] SRC_SELF = 3'd0;
  localparam logic [SEL_W-1:0] SRC_N    = 3'd1;
  localparam logic [SEL_W-1:0] SRC_S    = 3'd2;
  localparam logic [SEL_W-1:0] SRC_E    = 3'd3;
  localparam logic [SEL_W-1:0] SRC_W    = 3'd4;

  typedef struct packed {
    logic [NUM_DIR-1:0][SEL_W-1:0] out_sel;
    logic [LUT_IN-1:0][SEL_W-1:0]  in_sel;
    logic [LUT_W-1:0]              lut;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/rbn_src_mux.sv
module rbn_src_mux
  import rbn_pkg::*;
(
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               self_i,
  input  logic [NUM_DIR-1:0] nbr_i,
  output logic               sig_o
);
  always_comb begin
    unique case (sel_i)
      SRC_SELF: sig_o = self_i;
      SRC_N:    sig_o = nbr_i[0];
      SRC_S:    sig_o = nbr_i[1];
      SRC_E:    sig_o = nbr_i[2];
      SRC_W:    sig_o = nbr_i[3];
      default:  sig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rbn_cell.sv
module rbn_cell
  import rbn_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  cell_cfg_t          cfg_i,
  input  logic               seed_we_i,
  input  logic               seed_i,
  input  logic               step_i,
  input  logic [NUM_DIR-1:0] nbr_i,
  output logic               state_o,
  output logic [NUM_DIR-1:0] out_o
);
  cell_cfg_t         cfg_q;
  logic              state_q;
  logic [LUT_IN-1:0] lut_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_i;
  end

  for (genvar k = 0; k < LUT_IN; k++) begin : g_in
    rbn_src_mux u_in_mux (
      .sel_i (cfg_q.in_sel[k]),
      .self_i(state_q),
      .nbr_i (nbr_i),
      .sig_o (lut_idx[k])
    );
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_out
    rbn_src_mux u_out_mux (
      .sel_i (cfg_q.out_sel[d]),
      .self_i(state_q),
      .nbr_i (nbr_i),
      .sig_o (out_o[d])
    );
  end

  // seed wins over step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= 1'b0;
    else if (seed_we_i) state_q <= seed_i;
    else if (step_i)    state_q <= cfg_q.lut[lut_idx];
  end

  assign state_o = state_q;

  p_cfg_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_q == $past(cfg_i));
  p_step_lut_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !seed_we_i) |=> state_o == $past(cfg_q.lut[lut_idx]));
  p_seed_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_we_i |=> state_o == $past(seed_i));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seed_we_i && !step_i) |=> $stable(state_o));
endmodule

// File: rtl/rbn_array.sv
module rbn_array
  import rbn_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int NUM_CELLS = ROWS * COLS,
  localparam int ADDR_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [CFG_W-1:0]     cfg_data_i,
  input  logic                 seed_we_i,
  input  logic [NUM_CELLS-1:0] seed_i,
  input  logic                 step_i,
  output logic [NUM_CELLS-1:0] state_o
);
  logic [NUM_CELLS-1:0][NUM_DIR-1:0] cell_out;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX   = r * COLS + c;
      localparam int IDX_N = ((r + ROWS - 1) % ROWS) * COLS + c;
      localparam int IDX_S = ((r + 1) % ROWS) * COLS + c;
      localparam int IDX_E = r * COLS + (c + 1) % COLS;
      localparam int IDX_W = r * COLS + (c + COLS - 1) % COLS;

      logic [NUM_DIR-1:0] nbr;
      // each input is the facing output of the neighbour
      assign nbr = {cell_out[IDX_W][2], cell_out[IDX_E][3],
                    cell_out[IDX_S][0], cell_out[IDX_N][1]};

      rbn_cell u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cfg_we_i (cfg_we_i && (cfg_addr_i == ADDR_W'(IDX))),
        .cfg_i    (cell_cfg_t'(cfg_data_i)),
        .seed_we_i(seed_we_i),
        .seed_i   (seed_i[IDX]),
        .step_i   (step_i),
        .nbr_i    (nbr),
        .state_o  (state_o[IDX]),
        .out_o    (cell_out[IDX])
      );
    end
  end
endmodule

// File: tb/rbn_array_bench.sv
module rbn_array_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [39:0] cfg_data = '0;
  logic        seed_we = 1'b0;
  logic [15:0] seed = '0;
  logic        step = 1'b0;
  logic [15:0] state;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rbn_array u_rbn_array (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .seed_we_i(seed_we), .seed_i(seed),
    .step_i(step), .state_o(state)
  );

  function automatic logic [39:0] mk_cfg(logic [15:0] lut, logic [2:0] i0, logic [2:0] i1,
      logic [2:0] i2, logic [2:0] i3, logic [2:0] on, logic [2:0] os, logic [2:0] oe,
      logic [2:0] ow);
    return {ow, oe, os, on, i3, i2, i1, i0, lut};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(int idx, logic [39:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'(idx); cfg_data = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic clr_cfg();
    for (int i = 0; i < 16; i++) wr_cfg(i, '0);
  endtask

  task automatic do_seed(logic [15:0] v);
    @(negedge clk); seed_we = 1'b1; seed = v;
    @(negedge clk); seed_we = 1'b0;
  endtask

  task automatic do_step();
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset state", state, 16'h0000);
    do_seed(16'hFFFF);
    do_step();
    chk("R1 zero config after reset", state, 16'h0000);
  endtask

  task automatic t_seed_hold();
    clr_cfg();
    do_seed(16'hA5C3);
    chk("R8 seed load", state, 16'hA5C3);
    repeat (3) @(negedge clk);
    chk("R9 hold without step", state, 16'hA5C3);
    @(negedge clk); seed_we = 1'b1; seed = 16'h3C5A; step = 1'b1;
    @(negedge clk); seed_we = 1'b0; step = 1'b0;
    chk("R8 seed over step", state, 16'h3C5A);
  endtask

  task automatic t_cfg_index();
    clr_cfg();
    wr_cfg(7, mk_cfg(16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0));
    do_seed(16'h0000);
    do_step();
    chk("R2 only addressed cell", state, 16'h0080);
  endtask

  task automatic t_lut_addr();
    clr_cfg();
    for (int idx = 0; idx < 16; idx++) begin
      logic [15:0] sd;
      sd = '0;
      sd[10] = idx[0]; sd[6] = idx[1]; sd[11] = idx[2]; sd[9] = idx[3];
      wr_cfg(10, mk_cfg(16'(1 << idx), 0, 1, 3, 4, 0, 0, 0, 0));
      do_seed(sd); do_step();
      chk("R3 one-hot table", {15'd0, state[10]}, 16'd1);
      wr_cfg(10, mk_cfg(~16'(1 << idx), 0, 1, 3, 4, 0, 0, 0, 0));
      do_seed(sd); do_step();
      chk("R3 complement table", {15'd0, state[10]}, 16'd0);
    end
  endtask

  task automatic t_sources();
    int src_cell[5] = '{5, 1, 9, 6, 4};
    clr_cfg();
    for (int s = 0; s < 5; s++) begin
      wr_cfg(5, mk_cfg(16'hAAAA, 3'(s), 0, 0, 0, 0, 0, 0, 0));
      do_seed(16'(1 << src_cell[s])); do_step();
      chk("R4 source picked", {15'd0, state[5]}, 16'd1);
      do_seed(~16'(1 << src_cell[s])); do_step();
      chk("R4 source isolated", {15'd0, state[5]}, 16'd0);
    end
    wr_cfg(5, mk_cfg(16'hAAAA, 5, 0, 0, 0, 0, 0, 0, 0));
    do_seed(16'hFFFF); do_step();
    chk("R4 code 5 is zero", {15'd0, state[5]}, 16'd0);
    wr_cfg(5, mk_cfg(16'h5555, 7, 0, 0, 0, 0, 0, 0, 0));
    do_seed(16'hFFFF); do_step();
    chk("R4 code 7 is zero", {15'd0, state[5]}, 16'd1);
  endtask

  task automatic t_wrap();
    clr_cfg();
    wr_cfg(0, mk_cfg(16'hAAAA, 1, 0, 0, 0, 0, 0, 0, 0));
    do_seed(16'h1000); do_step();
    chk("R6 north wraps", state, 16'h0001);
    wr_cfg(0, mk_cfg(16'hAAAA, 4, 0, 0, 0, 0, 0, 0, 0));
    do_seed(16'h0008); do_step();
    chk("R6 west wraps", state, 16'h0001);
  endtask

  task automatic t_sync();
    clr_cfg();
    wr_cfg(0, mk_cfg(16'hAAAA, 3, 0, 0, 0, 0, 0, 0, 0));
    wr_cfg(1, mk_cfg(16'hAAAA, 4, 0, 0, 0, 0, 0, 0, 0));
    do_seed(16'h0001); do_step();
    chk("R7 swap one", state, 16'h0002);
    do_step();
    chk("R7 swap two", state, 16'h0001);
  endtask

  task automatic t_bypass();
    clr_cfg();
    wr_cfg(2, mk_cfg(16'hAAAA, 4, 0, 0, 0, 0, 0, 0, 0));
    wr_cfg(1, mk_cfg(16'h0000, 0, 0, 0, 0, 0, 0, 4, 0));
    do_seed(16'h0001); do_step();
    chk("R5 pass-through link", state, 16'h0004);
    do_seed(16'h0002); do_step();
    chk("R5 pass-through hides own", state, 16'h0000);
    wr_cfg(1, mk_cfg(16'h0000, 0, 0, 0, 0, 0, 0, 5, 0));
    do_seed(16'h0003); do_step();
    chk("R5 code 5 sends zero", state, 16'h0000);
    wr_cfg(1, mk_cfg(16'h0000, 0, 0, 0, 0, 0, 0, 0, 0));
    do_seed(16'h0002); do_step();
    chk("R5 own state sent", state, 16'h0004);
  endtask

  task automatic t_asym();
    clr_cfg();
    wr_cfg(5, mk_cfg(16'hAAAA, 3, 0, 0, 0, 0, 0, 0, 0));
    wr_cfg(6, mk_cfg(16'hAAAA, 0, 0, 0, 0, 0, 0, 0, 0));
    do_seed(16'h0040); do_step();
    chk("R10 reader follows", state, 16'h0060);
    do_seed(16'h0020); do_step();
    chk("R10 source not driven back", state, 16'h0000);
  endtask

  task automatic t_dup();
    clr_cfg();
    wr_cfg(5, mk_cfg(16'h6666, 1, 1, 0, 0, 0, 0, 0, 0));
    do_seed(16'h0002); do_step();
    chk("R11 xor of same input", {15'd0, state[5]}, 16'd0);
    wr_cfg(5, mk_cfg(16'h6666, 1, 3, 0, 0, 0, 0, 0, 0));
    do_seed(16'h0002); do_step();
    chk("R11 xor of distinct inputs", {15'd0, state[5]}, 16'd1);
    wr_cfg(5, mk_cfg(16'h8888, 1, 1, 0, 0, 0, 0, 0, 0));
    do_seed(16'h0002); do_step();
    chk("R11 and of same input", {15'd0, state[5]}, 16'd1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seed_hold();
    t_cfg_index();
    t_lut_addr();
    t_sources();
    t_wrap();
    t_sync();
    t_bypass();
    t_asym();
    t_dup();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule